// File: doc/BRIEF.md
# Port-Write Receive Interrupt Controller

This block sits behind the maintenance logic of a serial interconnect endpoint and takes in port-write packets that have already been parsed. It holds one packet's payload at a time, up to four 32-bit words, in a single-entry buffer. For each arriving packet it decides whether to keep it or discard it. A packet is discarded when reception is switched off or when the previous payload has not yet been read out. Each outcome raises its own sticky event flag.

Software reaches the block through a plain word-addressed register port. That port covers the event flags, an interrupt mask, a receive control bit and the payload words. Each event flag stays set until software writes a 1 to it. A single registered, level-sensitive interrupt line reports when any unmasked flag is set. Reading the last payload word frees the buffer for the next packet.

Top module: `pw_irq_ctrl`

## Requirements
- R1: The status word (address 0) carries the error flag at bit 6, the discard flag at bit 5 and the keep flag at bit 4. Every other bit reads as zero, and all three flags are zero after reset.
- R2: Writing a 1 to bit 6, 5 or 4 of address 0 clears that flag. Writing a 0 leaves the flag unchanged.
- R3: When bit 0 of the receive control register (address 2) is 0, an arriving packet is not stored and the discard flag is set.
- R4: When the buffer already holds an unread payload, an arriving packet is discarded and the discard flag is set. The held payload stays unchanged.
- R5: An accepted packet sets the keep flag. Its payload word i (input bits 32i+31..32i) becomes readable at address 4+i.
- R6: A read of address 7, the last payload word, empties the buffer, so the following packet is accepted.
- R7: A one-cycle error strobe sets the error flag. A packet that arrives together with the strobe is neither stored nor flagged as discarded.
- R8: The interrupt output is a register that holds the OR of (flag AND mask) over the three flags, so it follows them one cycle later. The mask sits at address 1, bits 6..4, in the same positions as the flags.
- R9: When a hardware event and a write-1-to-clear reach the same flag in the same cycle, the flag ends up set.
- R10: Read data is registered and is valid in the cycle after the read strobe. The mask and receive control registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pw_valid_i | input | 1 | One-cycle strobe: a port-write packet is presented |
| pw_err_i | input | 1 | One-cycle strobe: the packet or the receive path is faulty |
| pw_payload_i | input | 128 | Packet payload, word i at bits 32i+31..32i |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 4 | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid one cycle after reg_rd_i |
| irq_o | output | 1 | Level interrupt request |

## Verification
A packet or a write strobe sampled at clock edge k changes the flags and the buffer at edge k. A read issued at edge k presents its data after the same edge, and the interrupt line moves one edge later, at k+1. The driver tasks apply stimulus on falling edges. The monitor compares read data at the falling edge that follows the read's rising edge. Interrupt checks are placed one falling edge after a change of flag or mask, so the bench also observes the one-cycle lag in which the line still shows the old value.

// File: rtl/pw_irq_pkg.sv
package pw_irq_pkg;

  // Bit positions of the event flags inside the status and mask words.
  localparam int FLAG_ERR_BIT  = 6;
  localparam int FLAG_DROP_BIT = 5;
  localparam int FLAG_KEEP_BIT = 4;

  // Word addresses of the register port.
  localparam int ADDR_STATUS = 0;
  localparam int ADDR_MASK   = 1;
  localparam int ADDR_CTRL   = 2;
  localparam int ADDR_PW0    = 4;

  // Bit of the receive control register that allows packets in.
  localparam int CTRL_RX_EN_BIT = 0;

  typedef struct packed {
    logic err;
    logic drop;
    logic keep;
  } pw_evt_t;

endpackage

// File: rtl/pw_rx_buffer.sv
module pw_rx_buffer
  import pw_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pw_valid_i,
  input  logic                    pw_err_i,
  input  logic                    rx_en_i,
  input  logic [WORDS*DATA_W-1:0] payload_i,
  input  logic                    release_i,
  output logic                    buf_valid_o,
  output logic [WORDS*DATA_W-1:0] payload_o,
  output pw_evt_t                 evt_o
);

  logic buf_valid_q, buf_valid_d;
  logic accept, drop, clean;

  // A packet with an error strobe takes neither path.
  assign clean  = pw_valid_i & ~pw_err_i;
  assign accept = clean & rx_en_i & ~buf_valid_q;
  assign drop   = clean & ~accept;

  always_comb begin
    evt_o.err  = pw_err_i;
    evt_o.drop = drop;
    evt_o.keep = accept;
  end

  always_comb begin
    buf_valid_d = buf_valid_q;
    if (accept) begin
      buf_valid_d = 1'b1;
    end else if (release_i) begin
      buf_valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_valid_q <= 1'b0;
    end else begin
      buf_valid_q <= buf_valid_d;
    end
  end

  // One register per payload word, loaded only when a packet is accepted.
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (accept) begin
        word_q <= payload_i[w*DATA_W +: DATA_W];
      end
    end
    assign payload_o[w*DATA_W +: DATA_W] = word_q;
  end

  assign buf_valid_o = buf_valid_q;

endmodule

// File: rtl/pw_irq_status.sv
module pw_irq_status
  import pw_irq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  pw_evt_t set_i,
  input  pw_evt_t clr_i,
  input  pw_evt_t mask_i,
  output pw_evt_t status_o,
  output logic    irq_o
);

  localparam int NFLAGS = $bits(pw_evt_t);

  logic [NFLAGS-1:0] set_v, clr_v, st_q, st_d;
  logic irq_q, irq_d;

  assign set_v = set_i;
  assign clr_v = clr_i;

  // Set has priority over clear, so that no event is lost.
  for (genvar b = 0; b < NFLAGS; b++) begin : g_flag
    always_comb begin
      st_d[b] = st_q[b];
      if (set_v[b]) begin
        st_d[b] = 1'b1;
      end else if (clr_v[b]) begin
        st_d[b] = 1'b0;
      end
    end
  end

  assign irq_d = |(st_q & mask_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      irq_q <= irq_d;
    end
  end

  assign status_o = st_q;
  assign irq_o    = irq_q;

endmodule

// File: rtl/pw_reg_if.sv
module pw_reg_if
  import pw_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int WORDS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr_i,
  input  logic                    reg_rd_i,
  input  logic [ADDR_W-1:0]       reg_addr_i,
  input  logic [DATA_W-1:0]       reg_wdata_i,
  input  pw_evt_t                 status_i,
  input  logic [WORDS*DATA_W-1:0] payload_i,
  output logic [DATA_W-1:0]       reg_rdata_o,
  output pw_evt_t                 mask_o,
  output logic                    rx_en_o,
  output pw_evt_t                 clr_o,
  output logic                    release_o
);

  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(ADDR_STATUS);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(ADDR_MASK);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_LAST   = ADDR_W'(ADDR_PW0 + WORDS - 1);

  pw_evt_t           mask_q, mask_d;
  logic              rx_en_q, rx_en_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              wr_status, wr_mask, wr_ctrl;
  pw_evt_t           wr_bits;

  assign wr_status = reg_wr_i & (reg_addr_i == A_STATUS);
  assign wr_mask   = reg_wr_i & (reg_addr_i == A_MASK);
  assign wr_ctrl   = reg_wr_i & (reg_addr_i == A_CTRL);

  always_comb begin
    wr_bits.err  = reg_wdata_i[FLAG_ERR_BIT];
    wr_bits.drop = reg_wdata_i[FLAG_DROP_BIT];
    wr_bits.keep = reg_wdata_i[FLAG_KEEP_BIT];
  end

  assign clr_o     = wr_status ? wr_bits : '0;
  assign release_o = reg_rd_i & (reg_addr_i == A_LAST);

  always_comb begin
    mask_d  = wr_mask ? wr_bits : mask_q;
    rx_en_d = wr_ctrl ? reg_wdata_i[CTRL_RX_EN_BIT] : rx_en_q;
  end

  always_comb begin
    rdata_d = '0;
    if (reg_addr_i == A_STATUS) begin
      rdata_d[FLAG_ERR_BIT]  = status_i.err;
      rdata_d[FLAG_DROP_BIT] = status_i.drop;
      rdata_d[FLAG_KEEP_BIT] = status_i.keep;
    end else if (reg_addr_i == A_MASK) begin
      rdata_d[FLAG_ERR_BIT]  = mask_q.err;
      rdata_d[FLAG_DROP_BIT] = mask_q.drop;
      rdata_d[FLAG_KEEP_BIT] = mask_q.keep;
    end else if (reg_addr_i == A_CTRL) begin
      rdata_d[CTRL_RX_EN_BIT] = rx_en_q;
    end
    for (int i = 0; i < WORDS; i++) begin
      if (reg_addr_i == ADDR_W'(ADDR_PW0 + i)) begin
        rdata_d = payload_i[i*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      rx_en_q <= 1'b0;
    end else begin
      mask_q  <= mask_d;
      rx_en_q <= rx_en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (reg_rd_i) begin
      rdata_q <= rdata_d;
    end
  end

  assign mask_o      = mask_q;
  assign rx_en_o     = rx_en_q;
  assign reg_rdata_o = rdata_q;

endmodule

// File: rtl/pw_irq_ctrl.sv
module pw_irq_ctrl
  import pw_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int WORDS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pw_valid_i,
  input  logic                    pw_err_i,
  input  logic [WORDS*DATA_W-1:0] pw_payload_i,
  input  logic                    reg_wr_i,
  input  logic                    reg_rd_i,
  input  logic [ADDR_W-1:0]       reg_addr_i,
  input  logic [DATA_W-1:0]       reg_wdata_i,
  output logic [DATA_W-1:0]       reg_rdata_o,
  output logic                    irq_o
);

  pw_evt_t                 evt, clr, mask, status;
  logic                    rx_en, buf_valid, release_buf;
  logic [WORDS*DATA_W-1:0] payload;

  pw_rx_buffer #(.DATA_W(DATA_W), .WORDS(WORDS)) u_buf (
    .clk         (clk),
    .rst_n       (rst_n),
    .pw_valid_i  (pw_valid_i),
    .pw_err_i    (pw_err_i),
    .rx_en_i     (rx_en),
    .payload_i   (pw_payload_i),
    .release_i   (release_buf),
    .buf_valid_o (buf_valid),
    .payload_o   (payload),
    .evt_o       (evt)
  );

  pw_irq_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (evt),
    .clr_i    (clr),
    .mask_i   (mask),
    .status_o (status),
    .irq_o    (irq_o)
  );

  pw_reg_if #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WORDS(WORDS)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_i    (reg_wr_i),
    .reg_rd_i    (reg_rd_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .status_i    (status),
    .payload_i   (payload),
    .reg_rdata_o (reg_rdata_o),
    .mask_o      (mask),
    .rx_en_o     (rx_en),
    .clr_o       (clr),
    .release_o   (release_buf)
  );

endmodule

// File: rtl/pw_irq_ctrl_chk.sv
module pw_irq_ctrl_chk
  import pw_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int WORDS  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    pw_valid_i,
  input logic                    pw_err_i,
  input logic                    reg_wr_i,
  input logic                    reg_rd_i,
  input logic [ADDR_W-1:0]       reg_addr_i,
  input logic [DATA_W-1:0]       reg_wdata_i,
  input logic [DATA_W-1:0]       reg_rdata_o,
  input logic                    irq_o,
  input pw_evt_t                 status,
  input pw_evt_t                 mask,
  input logic                    rx_en,
  input logic                    buf_valid,
  input logic [WORDS*DATA_W-1:0] payload
);

  logic [DATA_W-1:0] rsv_mask;
  always_comb begin
    rsv_mask = '1;
    rsv_mask[FLAG_ERR_BIT]  = 1'b0;
    rsv_mask[FLAG_DROP_BIT] = 1'b0;
    rsv_mask[FLAG_KEEP_BIT] = 1'b0;
  end

  logic clean, last_rd, st_wr;
  assign clean   = pw_valid_i & ~pw_err_i;
  assign last_rd = reg_rd_i & (reg_addr_i == ADDR_W'(ADDR_PW0 + WORDS - 1));
  assign st_wr   = reg_wr_i & (reg_addr_i == ADDR_W'(ADDR_STATUS));

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_i && reg_addr_i == ADDR_W'(ADDR_STATUS)) |=> ((reg_rdata_o & rsv_mask) == '0)); // R1

  AST_W0_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && !reg_wdata_i[FLAG_DROP_BIT] && status.drop) |=> status.drop); // R2

  AST_DROP_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (clean && !rx_en) |=> status.drop); // R3

  AST_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (clean && buf_valid && !last_rd) |=> (status.drop && buf_valid && $stable(payload))); // R4

  AST_KEEP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (clean && rx_en && !buf_valid) |=> (status.keep && buf_valid)); // R5

  AST_LAST_READ_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (last_rd && !pw_valid_i) |=> !buf_valid); // R6

  AST_ERR_DISCARDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_valid_i && pw_err_i) |=> (status.err && $stable(payload))); // R7

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|(status & mask)))); // R8

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_err_i && st_wr && reg_wdata_i[FLAG_ERR_BIT]) |=> status.err); // R9

endmodule

bind pw_irq_ctrl pw_irq_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WORDS(WORDS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pw_valid_i  (pw_valid_i),
  .pw_err_i    (pw_err_i),
  .reg_wr_i    (reg_wr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o),
  .status      (status),
  .mask        (mask),
  .rx_en       (rx_en),
  .buf_valid   (buf_valid),
  .payload     (payload)
);

// File: tb/pw_irq_ctrl_tb.sv
module pw_irq_ctrl_tb;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int WORDS  = 4;

  logic                    clk;
  logic                    rst_n;
  logic                    pw_valid_i;
  logic                    pw_err_i;
  logic [WORDS*DATA_W-1:0] pw_payload_i;
  logic                    reg_wr_i;
  logic                    reg_rd_i;
  logic [ADDR_W-1:0]       reg_addr_i;
  logic [DATA_W-1:0]       reg_wdata_i;
  logic [DATA_W-1:0]       reg_rdata_o;
  logic                    irq_o;

  int n_checks = 0;
  int n_fails  = 0;
  logic [DATA_W-1:0] exp_q[$];
  string             tag_q[$];

  pw_irq_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WORDS(WORDS)) u_dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: a read accepted at a rising edge is compared at the next falling edge.
  initial begin
    forever begin
      @(posedge clk);
      if (reg_rd_i) begin
        @(negedge clk);
        if (exp_q.size() > 0) begin
          check(tag_q.pop_front(), reg_rdata_o, exp_q.pop_front());
        end
      end
    end
  end

  task automatic reg_write(input int addr, input logic [DATA_W-1:0] data);
    reg_wr_i    = 1'b1;
    reg_addr_i  = ADDR_W'(addr);
    reg_wdata_i = data;
    @(negedge clk);
    reg_wr_i    = 1'b0;
  endtask

  task automatic reg_read(input int addr, input logic [DATA_W-1:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    reg_rd_i   = 1'b1;
    reg_addr_i = ADDR_W'(addr);
    @(negedge clk);
    reg_rd_i   = 1'b0;
  endtask

  task automatic send_pw(input logic [WORDS*DATA_W-1:0] data, input logic err);
    pw_valid_i   = 1'b1;
    pw_err_i     = err;
    pw_payload_i = data;
    @(negedge clk);
    pw_valid_i   = 1'b0;
    pw_err_i     = 1'b0;
  endtask

  function automatic logic [WORDS*DATA_W-1:0] mk_pkt(input logic [7:0] id);
    logic [WORDS*DATA_W-1:0] p;
    for (int i = 0; i < WORDS; i++) p[i*DATA_W +: DATA_W] = {id, 8'hA0, 8'h00, 8'(i)};
    return p;
  endfunction

  function automatic logic [DATA_W-1:0] w(input logic [7:0] id, input int i);
    return {id, 8'hA0, 8'h00, 8'(i)};
  endfunction

  initial begin
    #400000;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pw_valid_i = 1'b0; pw_err_i = 1'b0; pw_payload_i = '0;
    reg_wr_i = 1'b0; reg_rd_i = 1'b0; reg_addr_i = '0; reg_wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R8 irq after reset", 32'(irq_o), 32'h0);
    reg_read(0, 32'h0, "R1 status reset");
    reg_read(1, 32'h0, "R10 mask reset");
    reg_read(2, 32'h0, "R10 ctrl reset");

    // Reception disabled.
    send_pw(mk_pkt(8'h01), 1'b0);
    reg_read(0, 32'h20, "R3 drop when disabled");
    reg_write(0, 32'h0);
    reg_read(0, 32'h20, "R2 write 0 keeps flag");
    reg_write(0, 32'h20);
    reg_read(0, 32'h0, "R2 write 1 clears");

    // Accept, then overflow.
    reg_write(2, 32'h1);
    send_pw(mk_pkt(8'h11), 1'b0);
    reg_read(0, 32'h10, "R5 keep flag");
    reg_read(4, w(8'h11, 0), "R5 word0");
    reg_read(5, w(8'h11, 1), "R5 word1");
    reg_read(6, w(8'h11, 2), "R5 word2");
    send_pw(mk_pkt(8'h22), 1'b0);
    reg_read(0, 32'h30, "R4 drop when full");
    reg_read(4, w(8'h11, 0), "R4 payload held");
    reg_read(7, w(8'h11, 3), "R6 last word");
    reg_write(0, 32'h30);
    send_pw(mk_pkt(8'h33), 1'b0);
    reg_read(0, 32'h10, "R6 accepted after release");
    reg_read(4, w(8'h33, 0), "R6 new payload");

    // Error strobe with packet.
    send_pw(mk_pkt(8'h44), 1'b1);
    reg_read(0, 32'h50, "R7 error flag only");
    reg_read(4, w(8'h33, 0), "R7 payload untouched");

    // Interrupt timing.
    reg_write(1, 32'h40);
    check("R8 irq masked-in before update", 32'(irq_o), 32'h0);
    @(negedge clk);
    check("R8 irq asserted", 32'(irq_o), 32'h1);
    reg_write(0, 32'h40);
    check("R8 irq one-cycle lag", 32'(irq_o), 32'h1);
    @(negedge clk);
    check("R8 irq deasserted", 32'(irq_o), 32'h0);

    // Set and clear together.
    pw_err_i = 1'b1;
    reg_write(0, 32'h40);
    pw_err_i = 1'b0;
    reg_read(0, 32'h50, "R9 set beats clear");
    check("R8 irq from error", 32'(irq_o), 32'h1);

    reg_write(0, 32'hFFFF_FFFF);
    reg_read(0, 32'h0, "R1 all cleared, reserved zero");
    @(negedge clk);
    check("R8 irq cleared", 32'(irq_o), 32'h0);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule